// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading up to two descriptor words from a translation table in memory. A caller raises a lookup request with the virtual address and four attribute flags: instruction fetch, write, user mode and suppress-exception. The walker then reads the first-level descriptor through a simple request/valid memory port. When that descriptor points to a second-level table, it reads one more word. It then reports the outcome in a single-cycle `done` pulse. That outcome is either a physical address with its 2-bit access-permission code, domain number and sub-page hint, or a fault with a kind and a level. The four request flags come back unchanged with the result. A separate checker downstream uses the permission code and the flags to decide whether the access is allowed. That checker owns fault kind code 2 (permission), which the walker never produces.

The controller is a six-state machine. `IDLE` accepts a request (transition *accept*). `RD1` drives the first-level read for one cycle, and `WAIT1` holds until the read data returns. From `WAIT1`, a coarse-table descriptor with an open domain moves on to `RD2` (transition *descend*). Every other first-level outcome goes straight to `DONE` (transition *finish1*). `RD2` drives the second-level read, and `WAIT2` holds for its data before moving to `DONE` (transition *finish2*). `DONE` pulses `done` and returns to `IDLE` (transition *release*). Descriptor words can be byte-swapped before they are decoded, for big-endian tables. A mode input makes 1KB tiny-page descriptors map 4KB pages instead.

Top module: `ptw_walker`

## Requirements
- R1: One cycle after `req_valid` is sampled in idle, `busy` and `mem_req` are high for one cycle with `mem_addr` = {`tbl_base_hi`, va[31:20], 2'b00}.
- R2: A first-level descriptor whose bits [1:0] are 0 or 3 ends the walk with `fault`=1, `fault_kind`=0 (translation), `fault_level`=0 and `domain`=0.
- R3: The domain is first-level bits [8:5]; its 2-bit field in `dom_ctrl` starts at bit 2×domain. If that field is 0, the walk ends with `fault_kind`=1 (domain) and no second read. `fault_level` is 0 for a section and 1 for a coarse table.
- R4: A section (first-level bits [1:0]=2) gives `pa` = {d[31:20], va[19:0]}, `ap` = d[11:10] and `subpage`=0.
- R5: A coarse table (first-level bits [1:0]=1) triggers a second read, issued only after the first data returned, at {d[31:10], va[19:12], 2'b00}. At most one read is outstanding, and each `mem_req` lasts one cycle.
- R6: A second-level descriptor with bits [1:0]=0 ends the walk with `fault_kind`=0 and `fault_level`=1.
- R7: A large page (second-level type 1) gives `pa` = {s[31:16], va[15:0]}. `ap` is the pair s[4+2k+1:4+2k], with k = va[15:14].
- R8: A small page (type 2) gives `pa` = {s[31:12], va[11:0]}. `ap` is the pair s[4+2k+1:4+2k], with k = va[11:10].
- R9: A tiny page (type 3) gives `pa` = {s[31:10], va[9:0]} and `ap` = s[5:4]. With `tiny_as_4k`=1 it gives `pa` = {s[31:12], va[11:0]} and `ap` = s[5:4] instead.
- R10: `subpage` is 1 for tiny pages when `tiny_as_4k`=0. It is also 1 for small pages whose four permission pairs are not all equal. In every other case it is 0.
- R11: With `big_endian`=1, each word on `mem_rdata` is byte-reversed before it is decoded.
- R12: `busy` stays high from the cycle after acceptance through the `done` cycle. `done` lasts one cycle, and `req_valid` or `req_vaddr` changes while busy have no effect on the walk.
- R13: With `done`, `rsp_flags` returns {instr, write, user, noexc} as they were sampled at acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request, sampled in idle |
| req_vaddr | input | 32 | Virtual address |
| req_instr | input | 1 | Instruction-fetch flag |
| req_write | input | 1 | Write flag |
| req_user | input | 1 | User-mode flag |
| req_noexc | input | 1 | Suppress-exception flag |
| tbl_base_hi | input | 18 | First-level table base, address bits [31:14] |
| dom_ctrl | input | 32 | Sixteen 2-bit domain access fields |
| big_endian | input | 1 | Byte-swap descriptor words |
| tiny_as_4k | input | 1 | Map tiny descriptors as 4KB pages |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request (one cycle) |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result pulse |
| fault | output | 1 | Walk faulted |
| fault_kind | output | 2 | 0 translation, 1 domain |
| fault_level | output | 1 | 0 first level, 1 second level |
| pa | output | 32 | Physical address |
| ap | output | 2 | Selected access-permission code |
| domain | output | 4 | Descriptor domain |
| subpage | output | 1 | Sub-page granularity hint |
| rsp_flags | output | 4 | Echoed {instr, write, user, noexc} |

## Verification
Directed walks cover these cases:
- Each first-level type.
- A closed domain on both a section and a coarse table.
- Each second-level type, with every value of the permission-select bits.
- Small pages with equal and with unequal permission pairs, which separates the two `subpage` outcomes.
- Tiny pages with the 4KB mode both on and off.

The directed walks are repeated with big-endian tables, so a missing or misplaced byte swap shows up as a wrong type or address. Random descriptors, domain settings, read latencies and modes then exercise the address joins and field selects across the whole word. Some random walks also change `req_vaddr` and hold `req_valid` high while the walker is busy, so any resampling shows up as a wrong address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int WORD_W   = 32;
    localparam int DOM_W    = 4;
    localparam int AP_W     = 2;
    localparam int BASE_LO  = 14;
    localparam int BASE_W   = WORD_W - BASE_LO;
    localparam int NDOM     = 1 << DOM_W;
    localparam int BYTES    = WORD_W / 8;
    localparam int FLAG_W   = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD1, ST_WAIT1, ST_RD2, ST_WAIT2, ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FK_TRANS  = 2'd0,
        FK_DOMAIN = 2'd1,
        FK_PERM   = 2'd2
    } fault_kind_t;

    typedef enum logic [1:0] {
        L1_FAULT, L1_COARSE, L1_SECTION
    } l1_kind_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < BYTES; i++)
            r[8*i +: 8] = w[8*(BYTES-1-i) +: 8];
        return r;
    endfunction
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
    import ptw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] vaddr,
    input  logic [WORD_W-1:0] dom_ctrl,
    output l1_kind_t          kind,
    output logic [DOM_W-1:0]  dom,
    output logic              dom_open,
    output logic [WORD_W-1:0] sec_pa,
    output logic [AP_W-1:0]   sec_ap,
    output logic [WORD_W-1:0] l2_addr
);
    logic [2*NDOM-1:0] dom_fields;
    logic              unused_bits;

    assign dom_fields  = dom_ctrl[2*NDOM-1:0];
    assign unused_bits = ^{word[9], word[4:2], vaddr[11:0]};
    assign dom         = word[8:5];
    assign dom_open    = |dom_fields[2*dom +: 2];
    assign sec_pa      = {word[31:20], vaddr[19:0]};
    assign sec_ap      = word[11:10];
    assign l2_addr     = {word[31:10], vaddr[19:12], 2'b00};

    always_comb begin
        unique case (word[1:0])
            2'd1:    kind = L1_COARSE;
            2'd2:    kind = L1_SECTION;
            default: kind = L1_FAULT;
        endcase
    end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
    import ptw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic [WORD_W-1:0] vaddr,
    input  logic              tiny_as_4k,
    output logic              l2_fault,
    output logic [WORD_W-1:0] pa,
    output logic [AP_W-1:0]   ap,
    output logic              subpage
);
    logic [AP_W-1:0] pair [4];
    logic            pairs_equal;
    logic            unused_va;

    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_pair
            assign pair[g] = word[4 + 2*g +: 2];
        end
    endgenerate

    assign pairs_equal = (pair[0] == pair[1]) && (pair[0] == pair[2]) && (pair[0] == pair[3]);
    assign unused_va   = ^vaddr[31:16];

    always_comb begin
        l2_fault = 1'b0;
        pa       = '0;
        ap       = '0;
        subpage  = 1'b0;
        unique case (word[1:0])
            2'd0: l2_fault = 1'b1;
            2'd1: begin
                pa = {word[31:16], vaddr[15:0]};
                ap = pair[vaddr[15:14]];
            end
            2'd2: begin
                pa      = {word[31:12], vaddr[11:0]};
                ap      = pair[vaddr[11:10]];
                subpage = !pairs_equal;
            end
            default: begin
                ap = pair[0];
                if (tiny_as_4k) begin
                    pa = {word[31:12], vaddr[11:0]};
                end else begin
                    pa      = {word[31:10], vaddr[9:0]};
                    subpage = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic        req_instr,
    input  logic        req_write,
    input  logic        req_user,
    input  logic        req_noexc,
    input  logic [17:0] tbl_base_hi,
    input  logic [31:0] dom_ctrl,
    input  logic        big_endian,
    input  logic        tiny_as_4k,
    output logic        busy,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rvalid,
    input  logic [31:0] mem_rdata,
    output logic        done,
    output logic        fault,
    output logic [1:0]  fault_kind,
    output logic        fault_level,
    output logic [31:0] pa,
    output logic [1:0]  ap,
    output logic [3:0]  domain,
    output logic        subpage,
    output logic [3:0]  rsp_flags
);
    walk_state_t       state, state_nx;
    logic [WORD_W-1:0] va_q, l2a_q, rd_word;
    logic [FLAG_W-1:0] flg_q;

    l1_kind_t          l1_kind;
    logic [DOM_W-1:0]  l1_dom;
    logic              l1_dom_open;
    logic [WORD_W-1:0] l1_sec_pa, l1_l2_addr;
    logic [AP_W-1:0]   l1_sec_ap;

    logic              l2_fault, l2_sub;
    logic [WORD_W-1:0] l2_pa;
    logic [AP_W-1:0]   l2_ap;

    assign rd_word = big_endian ? swap_bytes(mem_rdata) : mem_rdata;

    ptw_l1_dec u_l1 (
        .word(rd_word), .vaddr(va_q), .dom_ctrl(dom_ctrl),
        .kind(l1_kind), .dom(l1_dom), .dom_open(l1_dom_open),
        .sec_pa(l1_sec_pa), .sec_ap(l1_sec_ap), .l2_addr(l1_l2_addr)
    );

    ptw_l2_dec u_l2 (
        .word(rd_word), .vaddr(va_q), .tiny_as_4k(tiny_as_4k),
        .l2_fault(l2_fault), .pa(l2_pa), .ap(l2_ap), .subpage(l2_sub)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: accept, descend, finish1, finish2, release
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = ST_RD1;
            ST_RD1:   state_nx = ST_WAIT1;
            ST_WAIT1: if (mem_rvalid)
                          state_nx = (l1_kind == L1_COARSE && l1_dom_open) ? ST_RD2 : ST_DONE;
            ST_RD2:   state_nx = ST_WAIT2;
            ST_WAIT2: if (mem_rvalid) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
    assign mem_req  = (state == ST_RD1) || (state == ST_RD2);
    assign mem_addr = (state == ST_RD2) ? l2a_q : {tbl_base_hi, va_q[31:20], 2'b00};
    assign rsp_flags = flg_q;

    // Datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q <= '0; l2a_q <= '0; flg_q <= '0;
            fault <= 1'b0; fault_kind <= FK_TRANS; fault_level <= 1'b0;
            pa <= '0; ap <= '0; domain <= '0; subpage <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q  <= req_vaddr;
                    flg_q <= {req_instr, req_write, req_user, req_noexc};
                end
                ST_WAIT1: if (mem_rvalid) begin
                    subpage <= 1'b0;
                    if (l1_kind == L1_FAULT) begin
                        fault <= 1'b1; fault_kind <= FK_TRANS;
                        fault_level <= 1'b0; domain <= '0;
                    end else if (!l1_dom_open) begin
                        fault <= 1'b1; fault_kind <= FK_DOMAIN;
                        fault_level <= (l1_kind == L1_COARSE); domain <= l1_dom;
                    end else if (l1_kind == L1_SECTION) begin
                        fault <= 1'b0; pa <= l1_sec_pa; ap <= l1_sec_ap;
                        domain <= l1_dom;
                    end else begin
                        l2a_q <= l1_l2_addr; domain <= l1_dom;
                    end
                end
                ST_WAIT2: if (mem_rvalid) begin
                    fault <= l2_fault; fault_kind <= FK_TRANS; fault_level <= 1'b1;
                    pa <= l2_pa; ap <= l2_ap; subpage <= l2_sub;
                end
                default: ;
            endcase
        end
    end

    // Assertions
    p_single_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_at_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    p_accept_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && mem_req));
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done));
endmodule

// File: tb/ptw_walker_bench.sv
`timescale 1ns/1ps
module ptw_walker_bench;
    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_instr = 0, req_write = 0, req_user = 0, req_noexc = 0;
    logic [31:0] req_vaddr = 0, dom_ctrl = 32'hFFFF_FFFF, mem_rdata = 0;
    logic [17:0] tbl_base_hi = 18'h2_1A3C;
    logic        big_endian = 0, tiny_as_4k = 0, mem_rvalid = 0;
    logic        busy, mem_req, done, fault, fault_level, subpage;
    logic [31:0] mem_addr, pa;
    logic [1:0]  fault_kind, ap;
    logic [3:0]  domain, rsp_flags;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    ptw_walker u_ptw_walker (.*);

    typedef struct packed {
        logic [31:0] a1; logic need2; logic [31:0] a2; logic flt; logic [1:0] kind;
        logic lvl; logic [31:0] pa; logic [1:0] ap; logic [3:0] dom; logic sub;
    } exp_t;

    task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic model(input logic [31:0] va, l1w, l2w, output exp_t e, output string tg);
        logic [3:0] d; logic [1:0] dav; int k;
        e = '0;
        e.a1 = {tbl_base_hi, va[31:20], 2'b00};
        d = l1w[8:5];
        dav = dom_ctrl[2*d +: 2];
        if (l1w[1:0] == 2'd0 || l1w[1:0] == 2'd3) begin
            e.flt = 1; e.kind = 0; e.lvl = 0; e.dom = 0; tg = "R2";
        end else if (dav == 2'd0) begin
            e.flt = 1; e.kind = 1; e.lvl = (l1w[1:0] == 2'd1); e.dom = d; tg = "R3";
        end else if (l1w[1:0] == 2'd2) begin
            e.pa = {l1w[31:20], va[19:0]}; e.ap = l1w[11:10]; e.dom = d; tg = "R4";
        end else begin
            e.need2 = 1; e.dom = d;
            e.a2 = {l1w[31:10], va[19:12], 2'b00};
            case (l2w[1:0])
                2'd0: begin e.flt = 1; e.kind = 0; e.lvl = 1; tg = "R6"; end
                2'd1: begin
                    k = int'(va[15:14]);
                    e.pa = {l2w[31:16], va[15:0]}; e.ap = l2w[4+2*k +: 2]; tg = "R7";
                end
                2'd2: begin
                    k = int'(va[11:10]);
                    e.pa = {l2w[31:12], va[11:0]}; e.ap = l2w[4+2*k +: 2];
                    e.sub = !(l2w[5:4] == l2w[7:6] && l2w[5:4] == l2w[9:8] && l2w[5:4] == l2w[11:10]);
                    tg = "R8";
                end
                default: begin
                    e.ap = l2w[5:4];
                    if (tiny_as_4k) e.pa = {l2w[31:12], va[11:0]};
                    else begin e.pa = {l2w[31:10], va[9:0]}; e.sub = 1; end
                    tg = "R9";
                end
            endcase
        end
    endtask

    task automatic serve(input logic [31:0] w, input int lat);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk(!mem_req, "R5 no second request while outstanding", {31'd0, mem_req}, 0);
        end
        mem_rvalid = 1;
        mem_rdata  = big_endian ? rev(w) : w;
        @(negedge clk);
        mem_rvalid = 0;
        mem_rdata  = $urandom;
    endtask

    task automatic walk(input logic [31:0] va, l1w, l2w, input logic [3:0] fl, input int lat, input bit junk);
        exp_t e; string tg;
        model(va, l1w, l2w, e, tg);
        @(negedge clk);
        req_valid = 1; req_vaddr = va;
        {req_instr, req_write, req_user, req_noexc} = fl;
        @(negedge clk);
        req_valid = junk; req_noexc = ~fl[0];
        if (junk) req_vaddr = ~va;
        chk(busy, "R12 busy after accept", {31'd0, busy}, 1);
        chk(mem_req && mem_addr == e.a1, "R1 first-level address", mem_addr, e.a1);
        serve(l1w, lat);
        if (e.need2) begin
            chk(mem_req && mem_addr == e.a2, "R5 second-level address", mem_addr, e.a2);
            serve(l2w, lat);
        end
        req_valid = 0;
        chk(done && busy, {tg, " done pulse"}, {30'd0, done, busy}, 3);
        chk(fault == e.flt, {tg, " fault"}, {31'd0, fault}, {31'd0, e.flt});
        chk(domain == e.dom, {tg, " R3 domain"}, {28'd0, domain}, {28'd0, e.dom});
        chk(rsp_flags == fl, "R13 flags echo", {28'd0, rsp_flags}, {28'd0, fl});
        if (e.flt) begin
            chk(fault_kind == e.kind && fault_level == e.lvl, {tg, " kind/level"},
                {29'd0, fault_kind, fault_level}, {29'd0, e.kind, e.lvl});
        end else begin
            chk(pa == e.pa, {tg, big_endian ? " R11 pa" : " pa"}, pa, e.pa);
            chk(ap == e.ap, {tg, " ap"}, {30'd0, ap}, {30'd0, e.ap});
            chk(subpage == e.sub, "R10 subpage", {31'd0, subpage}, {31'd0, e.sub});
        end
        @(negedge clk);
        chk(!done && !busy, "R12 release", {30'd0, done, busy}, 0);
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R12 reset state", {29'd0, busy, done, mem_req}, 0);
        rst_n = 1;
        for (int be = 0; be < 2; be++) begin
            big_endian = be[0];
            tiny_as_4k = 0;
            walk(32'h1234_5678, 32'hABC0_0000, 0, 4'hA, 1, 0);           // R2 type 0
            walk(32'h1234_5678, 32'hABC0_01E3, 0, 4'h5, 2, 0);           // R2 type 3
            walk(32'hFED1_2345, 32'h8760_0C42, 0, 4'h3, 1, 1);           // R4 section ap=3 dom 2
            dom_ctrl = 32'hFFFF_FFCF;                                    // domain 2 closed
            walk(32'hFED1_2345, 32'h8760_0C42, 0, 4'h1, 1, 0);           // R3 section level
            walk(32'hFED1_2345, 32'h4321_5441, 0, 4'h1, 1, 0);           // R3 coarse level
            dom_ctrl = 32'h5555_5555;
            walk(32'h0ABC_DEF0, 32'h4321_5421, 32'h1111_2220, 4'h2, 1, 0); // R6
            for (int k = 0; k < 4; k++) begin
                walk({16'h00AB, k[1:0], 14'h1F3}, 32'h4321_5421, 32'h9876_0E41, 4'h4, 1, 0); // R7
                walk({20'h00ABC, k[1:0], 10'h155}, 32'h4321_5421, 32'h9876_5E42, 4'h8, 1, 0); // R8 unequal
            end
            walk(32'h0ABC_D321, 32'h4321_5421, 32'h9876_5AAA, 4'h0, 1, 0); // R10 equal pairs
            walk(32'h0ABC_D321, 32'h4321_5421, 32'h9876_57E3, 4'hF, 3, 0); // R9 tiny
            tiny_as_4k = 1;
            walk(32'h0ABC_D321, 32'h4321_5421, 32'h9876_57E3, 4'hF, 1, 0); // R9 tiny as 4KB
        end
        for (int n = 0; n < 600; n++) begin
            big_endian = $urandom % 2;
            tiny_as_4k = $urandom % 2;
            dom_ctrl   = $urandom | (($urandom % 4 == 0) ? 32'h0 : 32'h5555_5555);
            walk($urandom, $urandom, $urandom, 4'($urandom), 1 + ($urandom % 4), bit'($urandom % 2));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule